// File: doc/BRIEF.md
# Four-Pin Bridge PWM Generator

This block generates pulse-width modulated drive for up to four output pins, labelled A, B, C and D. A single 8-bit period timer sets the cycle. A 2-bit sub-count and a prescaler extend it to a 10-bit phase. That phase is compared against a 10-bit duty value, so the duty has four times finer resolution than the period register.

A mode field routes the modulated signal to the pins in one of four ways:
- a single output;
- a full-bridge drive in either direction;
- a complementary half-bridge pair, with a programmable dead time before each pin turns on.

Each pin pair has its own active level. A latched shutdown, tripped by selected fault inputs or by software, parks every used pin in a programmed safe state: inactive, active or released.

Software configures the block through a plain write strobe (`wr_en`, `wr_addr`, `wr_data`). The bus has no back-pressure: every write is accepted in the cycle it is presented. No data stream flows through the block, so no valid/ready handshake is used. The `cyc_start_o` pulse marks the first cycle of each period, so that neighbouring logic can align to it.

Top module: `epwm_bridge`

## Requirements
- R1: Register addresses are 0 control, 1 duty high byte, 2 period, 3 timer config, 4 dead time, 5 shutdown. The control fields are:
  - [7:6] mode;
  - [5:4] the two low duty bits;
  - [3:2] the enable code, where `11` turns the outputs on and any other value keeps every pin undriven at 0;
  - [1] A/C active-low;
  - [0] B/D active-low.
  The timer config fields are [2] run and [1:0] prescale. The shutdown register fields are:
  - [7] shutdown flag;
  - [6:4] fault source mask;
  - [3:2] A/C safe state;
  - [1:0] B/D safe state.
- R2: After reset all registers are zero except the period, which is 255. All output enables and pins are 0, and `cyc_start_o` is low.
- R3: With the timer running, a period lasts (period+1)×4×P clocks, where P is 1, 4 or 16 for prescale 00, 01 and 1x. `cyc_start_o` pulses once per period.
- R4: The modulated signal is active for duty×P clocks of each period, where duty is {high byte, low bits}.
- R5: A duty of zero keeps the modulated signal inactive for the whole period. A duty of at least 4×(period+1) keeps it active for the whole period.
- R6: A duty written mid-period takes effect only from the next period start.
- R7: Mode 00 drives the modulated signal on A only. B, C and D are not enabled.
- R8: Mode 01 holds A active and modulates D. Mode 11 holds C active and modulates B. In both modes B and C, or A and D, stay inactive, and all four pins are enabled.
- R9: Mode 10 drives A with the modulated signal and B with its complement, and C and D are not enabled. Each pin turns on only after the dead time (in clocks) has passed since the last edge of the modulated signal. A is therefore active for max(on−dead, 0) clocks and B for max(off−dead, 0) clocks.
- R10: A set active-low bit inverts the level of that pair's pins.
- R11: A fault input whose mask bit is set latches the shutdown flag. An unmasked fault has no effect on the outputs.
- R12: While shut down, a used pin takes its pair's safe state: 00 is the inactive level, 01 is the active level, and 1x means the output enable is low.
- R13: The shutdown flag stays set after the fault goes away. Writing bit 7 to 0 clears it only when no masked fault is present. Writing bit 7 to 1 forces a shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fault_i | input | 3 | Synchronous fault inputs, active high |
| pwm_o | output | 4 | Pin levels, bit 0 = A … bit 3 = D |
| pwm_oe | output | 4 | Pin output enables |
| cyc_start_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The hardest case to reach is the half-bridge with a dead time longer than one phase of the modulated signal. There, every edge reloads the blanking counter before it expires, so one or both pins never turn on. The random stimulus pairs short periods with dead times of up to 20 clocks to land there often. A directed case uses a dead time larger than the whole on-time.

The latched shutdown is also hard to reach from the ports. The stimulus holds a masked fault while software writes a clear, then removes the fault and checks that the safe state persists until a second clear.

// File: rtl/epwm_pkg.sv
package epwm_pkg;
  localparam int BUS_W    = 8;
  localparam int DUTY_FRAC = 2;
  localparam int NPIN     = 4;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_DUTY = 3'd1;
  localparam logic [2:0] A_PER  = 3'd2;
  localparam logic [2:0] A_TCFG = 3'd3;
  localparam logic [2:0] A_DEAD = 3'd4;
  localparam logic [2:0] A_SHDN = 3'd5;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'b00,
    MD_FWD    = 2'b01,
    MD_HALF   = 2'b10,
    MD_REV    = 2'b11
  } mode_e;
endpackage

// File: rtl/epwm_regs.sv
module epwm_regs
  import epwm_pkg::*;
#(
  parameter int TW   = 8,
  parameter int DBW  = 8,
  parameter int NFLT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [NFLT-1:0]   fault_i,
  output mode_e             mode,
  output logic              pwm_en,
  output logic              inv_ac,
  output logic              inv_bd,
  output logic [TW+DUTY_FRAC-1:0] duty_pend,
  output logic [TW-1:0]     period,
  output logic              run,
  output logic [1:0]        pre_sel,
  output logic [DBW-1:0]    dead,
  output logic              sd_active,
  output logic [1:0]        safe_ac,
  output logic [1:0]        safe_bd
);
  logic [BUS_W-1:0] ctrl_q;
  logic [TW-1:0]    duty_hi_q;
  logic [TW-1:0]    per_q;
  logic [2:0]       tcfg_q;
  logic [DBW-1:0]   dead_q;
  logic [NFLT-1:0]  mask_q;
  logic [3:0]       safe_q;
  logic             sd_q;
  logic             trip;
  logic             shdn_wr;
  logic             sd_n;

  assign trip    = |(fault_i & mask_q);
  assign shdn_wr = wr_en && (wr_addr == A_SHDN);

  always_comb begin
    if (trip)         sd_n = 1'b1;
    else if (shdn_wr) sd_n = wr_data[7];
    else              sd_n = sd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      duty_hi_q <= '0;
      per_q     <= '1;
      tcfg_q    <= '0;
      dead_q    <= '0;
      mask_q    <= '0;
      safe_q    <= '0;
      sd_q      <= 1'b0;
    end else begin
      sd_q <= sd_n;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: ctrl_q    <= wr_data;
          A_DUTY: duty_hi_q <= wr_data[TW-1:0];
          A_PER:  per_q     <= wr_data[TW-1:0];
          A_TCFG: tcfg_q    <= wr_data[2:0];
          A_DEAD: dead_q    <= wr_data[DBW-1:0];
          A_SHDN: begin
            mask_q <= wr_data[4 +: NFLT];
            safe_q <= wr_data[3:0];
          end
          default: ;
        endcase
      end
    end
  end

  assign mode      = mode_e'(ctrl_q[7:6]);
  assign pwm_en    = (ctrl_q[3:2] == 2'b11);
  assign inv_ac    = ctrl_q[1];
  assign inv_bd    = ctrl_q[0];
  assign duty_pend = {duty_hi_q, ctrl_q[5:4]};
  assign period    = per_q;
  assign run       = tcfg_q[2];
  assign pre_sel   = tcfg_q[1:0];
  assign dead      = dead_q;
  assign sd_active = sd_q;
  assign safe_ac   = safe_q[3:2];
  assign safe_bd   = safe_q[1:0];

  // R11: a masked fault latches shutdown on the next edge
  a_r11_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> sd_active);

  // R13: a software clear with no masked fault releases shutdown
  a_r13_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_wr && !wr_data[7] && !trip) |=> !sd_active);

  // R13: with no write and no fault, the flag keeps its value
  a_r13_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_wr && !trip) |=> $stable(sd_active));
endmodule

// File: rtl/epwm_timebase.sv
module epwm_timebase #(
  parameter int TW = 8,
  parameter int FW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [1:0]      pre_sel,
  input  logic [TW-1:0]   period,
  input  logic [TW+FW-1:0] duty_pend,
  output logic            mod_o,
  output logic            cyc_start_o
);
  localparam int CW = TW + FW;
  localparam int PW = 5;

  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] pre_lim;
  logic [TW-1:0] tmr;
  logic [FW-1:0] sub;
  logic [CW-1:0] duty_act;
  logic          tick;
  logic          last_sub;
  logic          at_end;
  logic          wrap;
  logic          cyc_q;

  always_comb begin
    case (pre_sel)
      2'b00:   pre_lim = PW'(1);
      2'b01:   pre_lim = PW'(4);
      default: pre_lim = PW'(16);
    endcase
  end

  assign tick     = run && (pre_cnt >= pre_lim - 1'b1);
  assign last_sub = &sub;
  assign at_end   = (tmr >= period);
  assign wrap     = tick && last_sub && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tmr      <= '0;
      sub      <= '0;
      duty_act <= '0;
      cyc_q    <= 1'b0;
    end else begin
      cyc_q <= wrap;
      if (!run || tick) pre_cnt <= '0;
      else              pre_cnt <= pre_cnt + 1'b1;
      if (tick) begin
        sub <= sub + 1'b1;
        if (last_sub) tmr <= at_end ? '0 : tmr + 1'b1;
      end
      if (wrap) duty_act <= duty_pend;
    end
  end

  assign mod_o       = run && (duty_act > {tmr, sub});
  assign cyc_start_o = cyc_q;

  // R6: the active duty only moves at a period boundary
  a_r6_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act));

  // R3: a wrap restarts the phase at zero and flags the period start
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (tmr == '0 && sub == '0 && cyc_start_o));

  // R3: the period-start pulse is a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_o |=> !cyc_start_o);
endmodule

// File: rtl/epwm_steer.sv
module epwm_steer
  import epwm_pkg::*;
#(
  parameter int DBW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  mode_e           mode,
  input  logic            inv_ac,
  input  logic            inv_bd,
  input  logic [DBW-1:0]  dead,
  input  logic            mod_i,
  input  logic            sd_i,
  input  logic [1:0]      safe_ac,
  input  logic [1:0]      safe_bd,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] oe_o
);
  logic            m_q;
  logic [DBW-1:0]  dcnt;
  logic            mchg;
  logic            gate;
  logic [NPIN-1:0] act;
  logic [NPIN-1:0] used;
  logic [NPIN-1:0] pin_n;
  logic [NPIN-1:0] oe_n;

  // dead-time blanking: every edge of the modulated signal reloads the counter
  assign mchg = mod_i ^ m_q;
  assign gate = mchg ? (dead == '0) : (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q  <= 1'b0;
      dcnt <= '0;
    end else begin
      m_q <= mod_i;
      if (mchg)             dcnt <= (dead == '0) ? '0 : dead - 1'b1;
      else if (dcnt != '0)  dcnt <= dcnt - 1'b1;
    end
  end

  always_comb begin
    act  = '0;
    used = '0;
    case (mode)
      MD_SINGLE: begin
        act[0] = mod_i;
        used   = 4'b0001;
      end
      MD_FWD: begin
        act[0] = 1'b1;
        act[3] = mod_i;
        used   = 4'b1111;
      end
      MD_HALF: begin
        act[0] = mod_i & gate;
        act[1] = ~mod_i & gate;
        used   = 4'b0011;
      end
      default: begin
        act[2] = 1'b1;
        act[1] = mod_i;
        used   = 4'b1111;
      end
    endcase
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam bit IS_AC = ((i % 2) == 0);
    logic       inv;
    logic [1:0] safe;
    logic       lvl;
    logic       drv;
    assign inv  = IS_AC ? inv_ac : inv_bd;
    assign safe = IS_AC ? safe_ac : safe_bd;
    assign drv  = en && used[i] && !(sd_i && safe[1]);
    assign lvl  = sd_i ? (safe == 2'b01) : act[i];
    assign pin_n[i] = drv ? (lvl ^ inv) : 1'b0;
    assign oe_n[i]  = drv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o <= '0;
      oe_o  <= '0;
    end else begin
      pin_o <= pin_n;
      oe_o  <= oe_n;
    end
  end

  // R7: single mode enables only pin A
  a_r7_single_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MD_SINGLE && !sd_i) |=> (oe_o == 4'b0001));

  // R8: forward bridge holds A at its active level
  a_r8_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MD_FWD && !sd_i) |=> (pin_o[0] == !$past(inv_ac)));

  // R9: right after an edge with nonzero dead time both half-bridge pins are inactive
  a_r9_blank_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MD_HALF && !sd_i && mchg && dead != '0)
      |=> (pin_o[1:0] == {$past(inv_bd), $past(inv_ac)}));

  // R12: a released safe state removes the A/C enables
  a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sd_i && safe_ac[1]) |=> (!oe_o[0] && !oe_o[2]));
endmodule

// File: rtl/epwm_bridge.sv
module epwm_bridge
  import epwm_pkg::*;
#(
  parameter int TW   = 8,
  parameter int DBW  = 8,
  parameter int NFLT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [NFLT-1:0]  fault_i,
  output logic [NPIN-1:0]  pwm_o,
  output logic [NPIN-1:0]  pwm_oe,
  output logic             cyc_start_o
);
  localparam int CW = TW + DUTY_FRAC;

  mode_e          mode;
  logic           pwm_en;
  logic           inv_ac;
  logic           inv_bd;
  logic [CW-1:0]  duty_pend;
  logic [TW-1:0]  period;
  logic           run;
  logic [1:0]     pre_sel;
  logic [DBW-1:0] dead;
  logic           sd_active;
  logic [1:0]     safe_ac;
  logic [1:0]     safe_bd;
  logic           mod;

  epwm_regs #(.TW(TW), .DBW(DBW), .NFLT(NFLT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_i(fault_i), .mode(mode), .pwm_en(pwm_en),
    .inv_ac(inv_ac), .inv_bd(inv_bd), .duty_pend(duty_pend),
    .period(period), .run(run), .pre_sel(pre_sel), .dead(dead),
    .sd_active(sd_active), .safe_ac(safe_ac), .safe_bd(safe_bd)
  );

  epwm_timebase #(.TW(TW), .FW(DUTY_FRAC)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel),
    .period(period), .duty_pend(duty_pend), .mod_o(mod),
    .cyc_start_o(cyc_start_o)
  );

  epwm_steer #(.DBW(DBW)) u_steer (
    .clk(clk), .rst_n(rst_n), .en(pwm_en), .mode(mode),
    .inv_ac(inv_ac), .inv_bd(inv_bd), .dead(dead), .mod_i(mod),
    .sd_i(sd_active), .safe_ac(safe_ac), .safe_bd(safe_bd),
    .pin_o(pwm_o), .oe_o(pwm_oe)
  );

  // R2: no pin is enabled while the enable code is off
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> (pwm_oe == '0 && pwm_o == '0));
endmodule

// File: tb/sim_epwm_bridge.sv
module sim_epwm_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fault_i = '0;
  logic [3:0] pwm_o;
  logic [3:0] pwm_oe;
  logic       cyc_start_o;

  int nchk = 0;
  int nfail = 0;
  int hi_c [4];
  logic [3:0] oe_c;
  bit oe_var;

  always #5 clk = ~clk;

  epwm_bridge u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_i(fault_i), .pwm_o(pwm_o),
    .pwm_oe(pwm_oe), .cyc_start_o(cyc_start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!cyc_start_o);
  endtask

  task automatic measure(input int n, input int mid_at, input logic [2:0] ma, input logic [7:0] md);
    for (int i = 0; i < 4; i++) hi_c[i] = 0;
    oe_var = 1'b0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (j == 0) oe_c = pwm_oe;
      else if (pwm_oe != oe_c) oe_var = 1'b1;
      for (int i = 0; i < 4; i++) if (pwm_o[i]) hi_c[i]++;
      if (j == mid_at) begin
        wr_en = 1'b1; wr_addr = ma; wr_data = md;
      end else wr_en = 1'b0;
    end
    wr_en = 1'b0;
  endtask

  function automatic int pre_of(input int ps);
    return (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
  endfunction

  function automatic int sat0(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  // expected active clocks per period for a pin, -1 when the pin is not enabled
  function automatic int exp_act(input int md, input int pin, input int per, input int mh, input int dl);
    case (md)
      0: return (pin == 0) ? mh : -1;
      1: return (pin == 0) ? per : (pin == 3) ? mh : 0;
      2: begin
        if (pin > 1) return -1;
        if (mh == 0 || mh == per) return (pin == 0) ? mh : per - mh;
        return (pin == 0) ? sat0(mh - dl) : sat0(per - mh - dl);
      end
      default: return (pin == 2) ? per : (pin == 1) ? mh : 0;
    endcase
  endfunction

  task automatic cfg(input int md, input int pol, input int pr, input int ps, input int duty, input int dl);
    wr(3'd4, 8'(dl));
    wr(3'd2, 8'(pr));
    wr(3'd1, 8'(duty >> 2));
    wr(3'd0, {2'(md), 2'(duty), 2'b11, 2'(pol)});
    wr(3'd3, {5'b0, 1'b1, 2'(ps)});
  endtask

  task automatic verify(input int md, input int pol, input int per, input int mh, input int dl, input string tag);
    for (int i = 0; i < 4; i++) begin
      int e;
      int x;
      bit inv;
      e = exp_act(md, i, per, mh, dl);
      if (e < 0) begin
        chk(oe_c[i] == 1'b0 && !oe_var, tag, int'(oe_c[i]), 0);
      end else begin
        inv = (i % 2 == 0) ? pol[1] : pol[0];
        x = inv ? per - e : e;
        chk(oe_c[i] == 1'b1 && !oe_var && hi_c[i] == x, tag, hi_c[i], x);
      end
    end
  endtask

  task automatic run_case(input int md, input int pol, input int pr, input int ps, input int duty, input int dl, input string tag);
    int per;
    int mh;
    int g;
    int full;
    per  = (pr + 1) * 4 * pre_of(ps);
    full = 4 * (pr + 1);
    mh   = ((duty < full) ? duty : full) * pre_of(ps);
    cfg(md, pol, pr, ps, duty, dl);
    wait_start(g);
    wait_start(g);
    wait_start(g);
    chk(g == per, "R3 period length", g, per);
    measure(per, -1, 3'd0, 8'd0);
    verify(md, pol, per, mh, dl, tag);
  endtask

  task automatic hold_check(input int pin, input bit exp_oe, input bit exp_lvl, input string tag);
    repeat (3) @(negedge clk);
    measure(8, -1, 3'd0, 8'd0);
    chk(oe_c[pin] == exp_oe && !oe_var, tag, int'(oe_c[pin]), int'(exp_oe));
    if (exp_oe)
      chk(hi_c[pin] == (exp_lvl ? 8 : 0), tag, hi_c[pin], exp_lvl ? 8 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int g;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(pwm_o == 4'b0 && pwm_oe == 4'b0 && !cyc_start_o, "R2 reset outputs", int'({pwm_oe, pwm_o}), 0);
    // R1 R2: enable single mode and run timer, period and duty at reset values
    wr(3'd0, 8'h0C);
    wr(3'd3, 8'h04);
    wait_start(g);
    wait_start(g);
    chk(g == 1024, "R2 default period 255", g, 1024);
    measure(16, -1, 3'd0, 8'd0);
    chk(oe_c == 4'b0001 && hi_c[0] == 0, "R2 R5 duty reset zero", hi_c[0], 0);

    // R5 duty boundaries
    run_case(0, 0, 9, 0, 0, 0, "R5 zero duty");
    run_case(0, 0, 9, 0, 40, 0, "R5 full duty");
    run_case(0, 2, 9, 0, 45, 0, "R5 R10 above full");
    // R3 R4 prescaler 16 and 4
    run_case(0, 0, 3, 2, 7, 0, "R3 R4 prescale 16");
    run_case(0, 0, 5, 1, 9, 0, "R3 R4 prescale 4");
    // R9 half bridge
    run_case(2, 0, 9, 0, 17, 0, "R9 no dead time");
    run_case(2, 1, 9, 0, 17, 5, "R9 R10 dead time");
    run_case(2, 0, 9, 0, 17, 30, "R9 dead beyond pulse");
    // R8 bridges
    run_case(1, 3, 6, 0, 11, 0, "R8 R10 forward");
    run_case(3, 0, 6, 0, 11, 0, "R8 reverse");

    // R6 mid-period duty update
    cfg(0, 0, 9, 0, 10, 0);
    wait_start(g); wait_start(g); wait_start(g);
    measure(40, 15, 3'd1, 8'd7);
    chk(hi_c[0] == 10, "R6 old duty kept", hi_c[0], 10);
    wait_start(g);
    measure(40, -1, 3'd0, 8'd0);
    chk(hi_c[0] == 30, "R6 new duty next period", hi_c[0], 30);

    // random configurations
    for (int k = 0; k < 12; k++) begin
      int md; int pol; int pr; int ps; int duty; int dl;
      md   = int'($urandom_range(3, 0));
      pol  = int'($urandom_range(3, 0));
      pr   = int'($urandom_range(12, 2));
      ps   = int'($urandom_range(2, 0));
      duty = int'($urandom_range(4 * (pr + 1) + 3, 0));
      dl   = int'($urandom_range(20, 0));
      if (md == 0)      run_case(md, pol, pr, ps, duty, dl, "R7 R4 R10 random");
      else if (md == 2) run_case(md, pol, pr, ps, duty, dl, "R9 R10 random");
      else              run_case(md, pol, pr, ps, duty, dl, "R8 R10 random");
    end

    // shutdown: single mode, duty half of 40 clocks
    run_case(0, 0, 9, 0, 20, 0, "R7 before shutdown");
    wr(3'd5, 8'h20);
    @(negedge clk);
    fault_i = 3'b001;
    wait_start(g);
    measure(40, -1, 3'd0, 8'd0);
    chk(hi_c[0] == 20 && oe_c[0], "R11 unmasked fault ignored", hi_c[0], 20);
    @(negedge clk);
    fault_i = 3'b011;
    hold_check(0, 1'b1, 1'b0, "R11 R12 safe inactive");
    wr(3'd5, 8'h24);
    hold_check(0, 1'b1, 1'b1, "R12 R13 safe active, clear blocked");
    wr(3'd5, 8'h28);
    hold_check(0, 1'b0, 1'b0, "R12 safe released");
    @(negedge clk);
    fault_i = 3'b000;
    hold_check(0, 1'b0, 1'b0, "R13 flag latched");
    wr(3'd0, 8'h0E);
    wr(3'd5, 8'h20);
    wr(3'd5, 8'hA0);
    hold_check(0, 1'b1, 1'b1, "R10 R13 forced shutdown active-low");
    wr(3'd5, 8'h20);
    wait_start(g); wait_start(g);
    measure(40, -1, 3'd0, 8'd0);
    chk(hi_c[0] == 20 && oe_c[0], "R13 cleared resumes", hi_c[0], 20);

    // R1: enable code other than 11 leaves pins undriven
    wr(3'd0, 8'h08);
    hold_check(0, 1'b0, 1'b0, "R1 enable code off");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule